// File: doc/BRIEF.md
# Displacement Address Generation Unit

This unit forms the 32-bit effective address of a load or store operand. It takes a base value and an offset and adds them. The base is either the general register Rn or a dedicated global base register. The offset is one of three things: a zero-extended displacement scaled by operand size, a zero-extended displacement left unscaled, or the index register R0. A two-bit mode code selects which combination is used.

The result is registered one clock after an input strobe. It comes with a valid strobe, a misalignment flag for the operand size and a flag for the reserved size code. Instruction decode, register file reads, the memory access itself and exception handling are left to the surrounding pipeline.

Top module: `disp_agu`

## Requirements
- R1: Mode code 00 (short displacement) gives EA = Rn + (zero-extended disp[3:0] shifted left by 0, 1 or 2) for size code 00 (byte), 01 (word) or 10 (longword).
- R2: Mode code 01 (long displacement) gives EA = Rn + zero-extended disp[11:0], never scaled, for every size code.
- R3: Mode code 10 (indexed) gives EA = Rn + R0, whatever the displacement input holds.
- R4: Mode code 11 (global base) gives EA = GBR + (zero-extended disp[7:0] shifted left by 0, 1 or 2) for byte, word or longword.
- R5: Size code 11 is reserved. It scales like a byte, and size_bad is 1 for that result. Every other size code gives size_bad = 0.
- R6: The addition wraps modulo 2^32 and no carry is reported.
- R7: ea_valid is 1 in exactly the cycle after a cycle with in_valid = 1 sampled at the rising edge.
- R8: While rst_n is low at a rising edge, ea_valid is 0 after that edge.
- R9: misalign is 1 when a word result has bit 0 set or a longword result has bit 1 or bit 0 set. It is always 0 for byte and reserved sizes.
- R10: Displacement bits above those used by the selected mode have no effect on the result.
- R11: ea, misalign and size_bad hold their value across cycles with in_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are present this cycle |
| mode | input | 2 | 00 short disp, 01 long disp, 10 indexed, 11 global base |
| size | input | 2 | 00 byte, 01 word, 10 longword, 11 reserved |
| rn | input | 32 | Base general register value |
| r0 | input | 32 | Index register value |
| gbr | input | 32 | Global base register value |
| disp | input | 12 | Raw displacement field |
| ea_valid | output | 1 | Registered result strobe |
| ea | output | 32 | Registered effective address |
| misalign | output | 1 | Result not aligned to the operand size |
| size_bad | output | 1 | Reserved size code was used |

## Verification
Every result (ea, misalign, size_bad and ea_valid) is due after the first rising edge that follows the cycle in which in_valid is sampled high. There is exactly one register stage. The bench changes inputs on falling edges and samples the outputs on the next falling edge, half a period after the capturing rising edge. To test holding, it idles a cycle and samples again. To test reset, it asserts rst_n low over one rising edge and reads ea_valid on the falling edge after it.

// File: rtl/dagu_pkg.sv
package dagu_pkg;

  typedef enum logic [1:0] {
    AM_SHORT  = 2'b00,
    AM_LONG   = 2'b01,
    AM_INDEX  = 2'b10,
    AM_GLOBAL = 2'b11
  } agu_mode_e;

  typedef enum logic [1:0] {
    OS_BYTE = 2'b00,
    OS_WORD = 2'b01,
    OS_LONG = 2'b10,
    OS_RSVD = 2'b11
  } agu_size_e;

  // Left-shift amount applied to a scaled displacement.
  function automatic logic [1:0] scale_shift(input logic [1:0] sz);
    case (sz)
      OS_WORD: scale_shift = 2'd1;
      OS_LONG: scale_shift = 2'd2;
      default: scale_shift = 2'd0;
    endcase
  endfunction

  function automatic logic size_reserved(input logic [1:0] sz);
    size_reserved = (sz == OS_RSVD);
  endfunction

  // Alignment test on the two low address bits.
  function automatic logic addr_misaligned(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      OS_WORD: addr_misaligned = lo[0];
      OS_LONG: addr_misaligned = |lo;
      default: addr_misaligned = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dagu_offset.sv
module dagu_offset
  import dagu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DISP_W   = 12,
  parameter int SHORT_W  = 4,
  parameter int GLOBAL_W = 8
) (
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] r0,
  output logic [ADDR_W-1:0] offset
);
  localparam int SHORT_SCALED_W  = SHORT_W + 2;
  localparam int GLOBAL_SCALED_W = GLOBAL_W + 2;

  logic [1:0]                 sh;
  logic [SHORT_SCALED_W-1:0]  short_scaled;
  logic [GLOBAL_SCALED_W-1:0] global_scaled;
  logic [ADDR_W-1:0]          long_ext;

  assign sh            = scale_shift(size);
  assign short_scaled  = SHORT_SCALED_W'(disp[SHORT_W-1:0]) << sh;
  assign global_scaled = GLOBAL_SCALED_W'(disp[GLOBAL_W-1:0]) << sh;
  assign long_ext      = ADDR_W'(disp);

  always_comb begin
    case (mode)
      AM_SHORT:  offset = ADDR_W'(short_scaled);
      AM_LONG:   offset = long_ext;
      AM_INDEX:  offset = r0;
      default:   offset = ADDR_W'(global_scaled);
    endcase
  end
endmodule

// File: rtl/dagu_base_sel.sv
module dagu_base_sel
  import dagu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] rn,
  input  logic [ADDR_W-1:0] gbr,
  output logic [ADDR_W-1:0] base
);
  assign base = (mode == AM_GLOBAL) ? gbr : rn;
endmodule

// File: rtl/dagu_align.sv
module dagu_align
  import dagu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic              mis,
  output logic              rsvd
);
  assign mis  = addr_misaligned(size, addr[1:0]);
  assign rsvd = size_reserved(size);
endmodule

// File: rtl/disp_agu.sv
module disp_agu
  import dagu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DISP_W   = 12,
  parameter int SHORT_W  = 4,
  parameter int GLOBAL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] rn,
  input  logic [ADDR_W-1:0] r0,
  input  logic [ADDR_W-1:0] gbr,
  input  logic [DISP_W-1:0] disp,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea,
  output logic              misalign,
  output logic              size_bad
);
  // Named internal events, visible to the bound checker.
  logic [ADDR_W-1:0] offset_w;
  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] ea_next_w;
  logic              mis_next_w;
  logic              rsvd_next_w;

  dagu_offset #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .SHORT_W(SHORT_W), .GLOBAL_W(GLOBAL_W)
  ) u_offset (
    .mode(mode), .size(size), .disp(disp), .r0(r0), .offset(offset_w)
  );

  dagu_base_sel #(.ADDR_W(ADDR_W)) u_base (
    .mode(mode), .rn(rn), .gbr(gbr), .base(base_w)
  );

  // Modulo 2^ADDR_W sum; carry out is dropped.
  assign ea_next_w = base_w + offset_w;

  dagu_align #(.ADDR_W(ADDR_W)) u_align (
    .size(size), .addr(ea_next_w), .mis(mis_next_w), .rsvd(rsvd_next_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_valid <= 1'b0;
      ea       <= '0;
      misalign <= 1'b0;
      size_bad <= 1'b0;
    end else begin
      ea_valid <= in_valid;
      if (in_valid) begin
        ea       <= ea_next_w;
        misalign <= mis_next_w;
        size_bad <= rsvd_next_w;
      end
    end
  end
endmodule

// File: rtl/disp_agu_chk.sv
module disp_agu_chk #(
  parameter int ADDR_W   = 32,
  parameter int DISP_W   = 12,
  parameter int SHORT_W  = 4,
  parameter int GLOBAL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        mode,
  input logic [1:0]        size,
  input logic [ADDR_W-1:0] rn,
  input logic [ADDR_W-1:0] r0,
  input logic [ADDR_W-1:0] gbr,
  input logic [DISP_W-1:0] disp,
  input logic              ea_valid,
  input logic [ADDR_W-1:0] ea,
  input logic              misalign,
  input logic              size_bad,
  input logic [ADDR_W-1:0] offset_w
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ea_valid);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !ea_valid);
  a_r8_reset_clears: assert property (@(posedge clk)
    !rst_n |=> !ea_valid);
  a_r3_indexed_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10) |=> ea == $past(rn + r0));
  a_r2_long_unscaled: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01) |=> ea == $past(rn + ADDR_W'(disp)));
  a_r4_global_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11 && size == 2'b00)
      |=> ea == $past(gbr + ADDR_W'(disp[GLOBAL_W-1:0])));
  a_r9_byte_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (size == 2'b00 || size == 2'b11)) |=> !misalign);
  a_r9_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'b01) |=> misalign == ea[0]);
  a_r9_long_align: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'b10) |=> misalign == (ea[1:0] != 2'b00));
  a_r5_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> size_bad == ($past(size) == 2'b11));
  a_r10_short_offset_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (offset_w >> (SHORT_W + 2)) == '0);
  a_r10_global_offset_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> (offset_w >> (GLOBAL_W + 2)) == '0);
  a_r11_hold_ea: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(rst_n)) |=> ($stable(ea) && $stable(misalign) && $stable(size_bad)));
endmodule

bind disp_agu disp_agu_chk #(
  .ADDR_W(ADDR_W), .DISP_W(DISP_W), .SHORT_W(SHORT_W), .GLOBAL_W(GLOBAL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .size(size),
  .rn(rn), .r0(r0), .gbr(gbr), .disp(disp), .ea_valid(ea_valid), .ea(ea),
  .misalign(misalign), .size_bad(size_bad), .offset_w(offset_w)
);

// File: tb/disp_agu_tb.sv
`timescale 1ns/1ps
module disp_agu_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  mode, size;
  logic [31:0] rn, r0, gbr;
  logic [11:0] disp;
  logic        ea_valid, misalign, size_bad;
  logic [31:0] ea;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  disp_agu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .size(size),
    .rn(rn), .r0(r0), .gbr(gbr), .disp(disp), .ea_valid(ea_valid), .ea(ea),
    .misalign(misalign), .size_bad(size_bad)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned mult_of(input logic [1:0] s);
    if (s == 2'b01) return 2;
    if (s == 2'b10) return 4;
    return 1;
  endfunction

  // Full-width sum so that a carry past bit 31 can be seen.
  function automatic logic [32:0] ref_sum(input logic [1:0] m, input logic [1:0] s,
      input logic [31:0] b, input logic [31:0] x, input logic [31:0] g, input logic [11:0] d);
    case (m)
      2'b00:   return {1'b0, b} + 33'(d % 16 * mult_of(s));
      2'b01:   return {1'b0, b} + 33'(d);
      2'b10:   return {1'b0, b} + {1'b0, x};
      default: return {1'b0, g} + 33'(d % 256 * mult_of(s));
    endcase
  endfunction

  task automatic drive(input logic [1:0] m, input logic [1:0] s, input logic [31:0] b,
                       input logic [31:0] x, input logic [31:0] g, input logic [11:0] d);
    in_valid = 1'b1; mode = m; size = s; rn = b; r0 = x; gbr = g; disp = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input logic [1:0] m, input logic [1:0] s, input logic [31:0] b,
                         input logic [31:0] x, input logic [31:0] g, input logic [11:0] d);
    logic [32:0] full;
    logic [31:0] e;
    logic        mis_e;
    string       tag;
    full = ref_sum(m, s, b, x, g, d);
    e = full[31:0];
    if (s == 2'b01)      mis_e = e[0];
    else if (s == 2'b10) mis_e = (e % 4) != 0;
    else                 mis_e = 1'b0;
    case (m)
      2'b00:   tag = "R1";
      2'b01:   tag = "R2";
      2'b10:   tag = "R3";
      default: tag = "R4";
    endcase
    drive(m, s, b, x, g, d);
    check("R7", "ea_valid", 32'(ea_valid), 32'd1);
    check(full[32] ? "R6" : tag, "ea", ea, e);
    check("R9", "misalign", 32'(misalign), 32'(mis_e));
    check("R5", "size_bad", 32'(size_bad), 32'(s == 2'b11));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    logic [31:0] ea_a;
    logic [11:0] dl [6];
    logic [31:0] bl [3];
    logic [31:0] xl [3];
    logic [31:0] gl [3];
    dl[0] = 12'h000; dl[1] = 12'hFFF; dl[2] = 12'h00F;
    dl[3] = 12'h0A5; dl[4] = 12'h5F3; dl[5] = 12'h801;
    bl[0] = 32'h0000_1000; xl[0] = 32'h0000_0020; gl[0] = 32'h8000_0000;
    bl[1] = 32'hFFFF_FFFE; xl[1] = 32'h0000_0003; gl[1] = 32'hFFFF_FF80;
    bl[2] = 32'h1234_5671; xl[2] = 32'hEDCB_A990; gl[2] = 32'h0000_0003;

    rst_n = 1'b0; in_valid = 1'b0; mode = '0; size = '0;
    rn = '0; r0 = '0; gbr = '0; disp = '0;
    repeat (3) @(negedge clk);
    check("R8", "ea_valid in reset", 32'(ea_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "idle ea_valid", 32'(ea_valid), 32'd0);

    // Sweep of modes, sizes, displacements and base sets.
    for (int bi = 0; bi < 3; bi++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 4; s++)
          for (int di = 0; di < 6; di++)
            run_one(2'(m), 2'(s), bl[bi], xl[bi], gl[bi], dl[di]);

    // R10: upper displacement bits do not change the address.
    for (int m = 0; m < 4; m++) begin
      drive(2'(m), 2'b10, 32'h0000_4000, 32'h0000_0100, 32'h0001_0000, 12'h003);
      ea_a = ea;
      drive(2'(m), 2'b10, 32'h0000_4000, 32'h0000_0100, 32'h0001_0000,
            (m == 1) ? 12'h003 : ((m == 3) ? 12'hF03 : 12'hFF3));
      check("R10", "ea with high disp bits", ea, ea_a);
    end

    // R11: outputs hold while idle.
    drive(2'b01, 2'b01, 32'h0000_0010, 32'h0, 32'h0, 12'h005);
    held = ea;
    rn = 32'hDEAD_BEEF; disp = 12'h777; size = 2'b11;
    @(negedge clk);
    check("R7", "ea_valid after idle", 32'(ea_valid), 32'd0);
    check("R11", "ea held", ea, held);
    check("R11", "misalign held", 32'(misalign), 32'd1);
    check("R11", "size_bad held", 32'(size_bad), 32'd0);

    // R8: reset during a request clears the strobe.
    in_valid = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", "ea_valid after reset", 32'(ea_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule